// File: doc/BRIEF.md
# Command-Byte Register Access Controller

This block sits between a serial target's byte engine and a bank of configuration and result registers. The byte engine reports transaction openings (with direction), received bytes, requests for an outgoing byte and stop conditions. The controller turns these events into register write strobes, read data and a one-cycle interrupt-clear pulse. It keeps a register pointer and an addressing mode that persist across transactions.

A received byte with its top bit set is a command. It either loads the pointer and picks fixed or incrementing addressing, or it issues a special function. A byte with the top bit clear is data for the current pointer. Colour channel results are 16 bits wide. Reading a channel's low byte freezes that channel's high byte, so the word read back is coherent even when a fresh conversion lands between the two byte reads.

Top module: `cmd_reg_access`

## Requirements
- R1: A byte written with bit 7 = 1 is a command. Bits 6:5 give the kind: 00 loads the pointer with bits 4:0 and selects fixed addressing; 01 loads the pointer and selects incrementing addressing.
- R2: Command kind 11 is a special function. Code 00110 in bits 4:0 drives `irq_clr` high for exactly the cycle after the byte. Code 00000 and every other code give no pulse. Kind 10 is ignored. Neither kind changes the pointer or the mode.
- R3: A byte written with bit 7 = 0 raises `reg_wr_en` in the next cycle, with `reg_wr_addr` equal to the pointer and `reg_wr_data` equal to the byte, when the pointer holds a writable address: 0x00, 0x01, 0x03, 0x04 to 0x07, 0x0C, 0x0D or 0x0F.
- R4: A data byte aimed at any other address (read-only or unmapped, including 0x02 and the identity register 0x12) produces no strobe. The identity register still reads 0x14 afterwards.
- R5: A read request raises `rd_valid` in the next cycle with `rd_data` taken from the current pointer. A read without a preceding command uses the stored pointer.
- R6: In fixed addressing, the pointer does not move on data writes or reads.
- R7: In incrementing addressing, the pointer advances by one after every data write or read, whether or not the target is writable, and wraps from 0x1F to 0x00.
- R8: Read map: writable addresses return `reg_rd_data` (the external register file, indexed by `reg_rd_addr`, which equals the pointer); 0x12 returns 0x14; 0x13 returns `status_in`; unmapped addresses return 0x00.
- R9: Channel k (k = 0..3) has its low byte at 0x14+2k and its high byte at 0x15+2k, sourced from `chan_data[16k+15:16k]`. A low-byte read returns the live low byte and captures the live high byte into that channel's shadow. A high-byte read returns the shadow, which is 0x00 after reset.
- R10: A stop closes the transaction and keeps the pointer and mode. Written bytes are honoured only inside an open write transaction, and read requests only inside an open read transaction. Other events produce no strobe, no read data and no pointer change.
- R11: After reset the pointer is 0x00, addressing is fixed, and `reg_wr_en`, `rd_valid` and `irq_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Transaction opens this cycle |
| ev_start_rd | input | 1 | Direction with `ev_start`: 1 read, 0 write |
| ev_wr | input | 1 | A byte was received |
| ev_wr_byte | input | 8 | Received byte |
| ev_rd | input | 1 | The engine asks for a byte to send |
| ev_stop | input | 1 | Transaction closes this cycle |
| reg_rd_data | input | 8 | External register file value at `reg_rd_addr` |
| status_in | input | 8 | Status byte for address 0x13 |
| chan_data | input | 64 | Live results of four 16-bit channels |
| reg_rd_addr | output | 5 | Current pointer, for the external read port |
| rd_data | output | 8 | Byte returned for a read request |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| reg_wr_en | output | 1 | Write strobe to the register file |
| reg_wr_addr | output | 5 | Write address |
| reg_wr_data | output | 8 | Write data |
| irq_clr | output | 1 | One-cycle interrupt-clear pulse |

## Verification
The two functions that can coincide are the capture of a channel's high byte into its shadow and the arrival of a new conversion result on `chan_data`. The bench changes a channel's live value on the same edge that samples a low-byte read. It then changes the value again before reading the high byte. The result passes only if the low byte shows the value present at that edge and the high byte shows the matching upper half, not the later one. The pointer advance during that same read is judged by which address the following read returns.

// File: rtl/cra_pkg.sv
package cra_pkg;

   typedef enum logic {
      AM_FIXED = 1'b0,
      AM_INCR  = 1'b1
   } addr_mode_e;

   localparam logic [1:0] CK_FIXED   = 2'b00;
   localparam logic [1:0] CK_INCR    = 2'b01;
   localparam logic [1:0] CK_RSVD    = 2'b10;
   localparam logic [1:0] CK_SPECIAL = 2'b11;

   localparam int         FIELD_W    = 5;
   localparam logic [4:0] SF_NOP     = 5'b00000;
   localparam logic [4:0] SF_IRQ_CLR = 5'b00110;

endpackage

// File: rtl/cra_txn.sv
module cra_txn (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_start,
   input  logic ev_start_rd,
   input  logic ev_stop,
   input  logic ev_wr,
   input  logic ev_rd,
   output logic txn_open,
   output logic wr_ok,
   output logic rd_ok
);

   logic dir_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txn_open <= 1'b0;
         dir_rd   <= 1'b0;
      end else if (ev_start) begin
         txn_open <= 1'b1;
         dir_rd   <= ev_start_rd;
      end else if (ev_stop) begin
         txn_open <= 1'b0;
      end
   end

   assign wr_ok = ev_wr & txn_open & ~dir_rd;
   assign rd_ok = ev_rd & txn_open &  dir_rd;

   a_r10_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop && !ev_start) |=> !txn_open);

   a_r10_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |=> txn_open);

endmodule

// File: rtl/cra_ptr_ctrl.sv
module cra_ptr_ctrl
   import cra_pkg::*;
#(
   parameter int AW = 5,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ok,
   input  logic [DW-1:0] wr_byte,
   input  logic          rd_ok,
   output logic [AW-1:0] ptr,
   output addr_mode_e    mode,
   output logic          data_wr,
   output logic          irq_clr
);

   logic                is_cmd;
   logic [1:0]          kind;
   logic [FIELD_W-1:0]  field;
   logic                loads_ptr;
   logic                access;

   assign is_cmd    = wr_ok &  wr_byte[DW-1];
   assign data_wr   = wr_ok & ~wr_byte[DW-1];
   assign kind      = wr_byte[6:5];
   assign field     = wr_byte[FIELD_W-1:0];
   assign loads_ptr = is_cmd & ((kind == CK_FIXED) | (kind == CK_INCR));
   assign access    = data_wr | rd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= '0;
         mode <= AM_FIXED;
      end else if (loads_ptr) begin
         ptr  <= field[AW-1:0];
         mode <= addr_mode_e'(kind[0]);
      end else if (access && mode == AM_INCR) begin
         ptr  <= ptr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_clr <= 1'b0;
      else        irq_clr <= is_cmd & (kind == CK_SPECIAL) & (field == SF_IRQ_CLR);
   end

   a_r7_incr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (access && mode == AM_INCR) |=> ptr == AW'($past(ptr) + 1'b1));

   a_r6_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (access && mode == AM_FIXED) |=> $stable(ptr));

   a_r2_special_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmd && wr_byte[6]) |=> ($stable(ptr) && $stable(mode)));

   a_r2_clr_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |-> $past(wr_ok));

endmodule

// File: rtl/cra_addr_map.sv
module cra_addr_map #(
   parameter int          AW        = 5,
   parameter int          DW        = 8,
   parameter int          NCH       = 4,
   parameter int          CH_BASE   = 20,
   parameter int          ID_ADDR   = 18,
   parameter int          STAT_ADDR = 19,
   parameter logic [7:0]  ID_VAL    = 8'h14,
   parameter logic [31:0] WR_MASK   = 32'h0000_B0FB
) (
   input  logic [AW-1:0]     ptr,
   input  logic [DW-1:0]     ext_rd,
   input  logic [DW-1:0]     status,
   input  logic [NCH*DW-1:0] chan_lo,
   input  logic [NCH*DW-1:0] shadow,
   output logic              writable,
   output logic [NCH-1:0]    lo_hit,
   output logic [DW-1:0]     rd_value
);

   logic [NCH-1:0] hi_hit;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int LO_ADDR = CH_BASE + 2 * i;
      assign lo_hit[i] = (ptr == AW'(LO_ADDR));
      assign hi_hit[i] = (ptr == AW'(LO_ADDR + 1));
   end

   assign writable = WR_MASK[ptr];

   always_comb begin
      rd_value = '0;
      if (writable) begin
         rd_value = ext_rd;
      end else if (ptr == AW'(ID_ADDR)) begin
         rd_value = DW'(ID_VAL);
      end else if (ptr == AW'(STAT_ADDR)) begin
         rd_value = status;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            if (lo_hit[i]) rd_value = chan_lo[i*DW +: DW];
            if (hi_hit[i]) rd_value = shadow[i*DW +: DW];
         end
      end
   end

   a_r9_one_channel: assert property (@(ptr) $onehot0({lo_hit, hi_hit}));

endmodule

// File: rtl/cra_shadow.sv
module cra_shadow #(
   parameter int NCH = 4,
   parameter int DW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    cap,
   input  logic [NCH*DW-1:0] hi_live,
   output logic [NCH*DW-1:0] hi_held
);

   for (genvar i = 0; i < NCH; i++) begin : g_sh
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      hi_held[i*DW +: DW] <= '0;
         else if (cap[i]) hi_held[i*DW +: DW] <= hi_live[i*DW +: DW];
      end

      a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !cap[i] |=> $stable(hi_held[i*DW +: DW]));

      a_r9_shadow_take: assert property (@(posedge clk) disable iff (!rst_n)
         cap[i] |=> hi_held[i*DW +: DW] == $past(hi_live[i*DW +: DW]));
   end

endmodule

// File: rtl/cmd_reg_access.sv
module cmd_reg_access
   import cra_pkg::*;
#(
   parameter int          AW        = 5,
   parameter int          DW        = 8,
   parameter int          NCH       = 4,
   parameter int          CW        = 16,
   parameter int          CH_BASE   = 20,
   parameter int          ID_ADDR   = 18,
   parameter int          STAT_ADDR = 19,
   parameter logic [7:0]  ID_VAL    = 8'h14,
   parameter logic [31:0] WR_MASK   = 32'h0000_B0FB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_start_rd,
   input  logic              ev_wr,
   input  logic [DW-1:0]     ev_wr_byte,
   input  logic              ev_rd,
   input  logic              ev_stop,
   input  logic [DW-1:0]     reg_rd_data,
   input  logic [DW-1:0]     status_in,
   input  logic [NCH*CW-1:0] chan_data,
   output logic [AW-1:0]     reg_rd_addr,
   output logic [DW-1:0]     rd_data,
   output logic              rd_valid,
   output logic              reg_wr_en,
   output logic [AW-1:0]     reg_wr_addr,
   output logic [DW-1:0]     reg_wr_data,
   output logic              irq_clr
);

   if (DW != 8) begin : g_bad_dw
      $error("command layout requires 8-bit bytes");
   end
   if (AW < 1 || AW > FIELD_W) begin : g_bad_aw
      $error("pointer width must fit the command address field");
   end
   if (CW != 2 * DW) begin : g_bad_cw
      $error("channel width must be two bytes");
   end
   if (CH_BASE + 2 * NCH > (1 << AW)) begin : g_bad_map
      $error("channel registers exceed the address space");
   end

   logic              txn_open;
   logic              wr_ok;
   logic              rd_ok;
   logic [AW-1:0]     ptr;
   addr_mode_e        mode;
   logic              data_wr;
   logic              writable;
   logic [NCH-1:0]    lo_hit;
   logic [DW-1:0]     rd_value;
   logic [NCH*DW-1:0] chan_lo;
   logic [NCH*DW-1:0] chan_hi;
   logic [NCH*DW-1:0] hi_held;

   for (genvar i = 0; i < NCH; i++) begin : g_split
      assign chan_lo[i*DW +: DW] = chan_data[i*CW      +: DW];
      assign chan_hi[i*DW +: DW] = chan_data[i*CW + DW +: DW];
   end

   cra_txn u_txn (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_start    (ev_start),
      .ev_start_rd (ev_start_rd),
      .ev_stop     (ev_stop),
      .ev_wr       (ev_wr),
      .ev_rd       (ev_rd),
      .txn_open    (txn_open),
      .wr_ok       (wr_ok),
      .rd_ok       (rd_ok)
   );

   cra_ptr_ctrl #(.AW(AW), .DW(DW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ok   (wr_ok),
      .wr_byte (ev_wr_byte),
      .rd_ok   (rd_ok),
      .ptr     (ptr),
      .mode    (mode),
      .data_wr (data_wr),
      .irq_clr (irq_clr)
   );

   cra_addr_map #(
      .AW(AW), .DW(DW), .NCH(NCH), .CH_BASE(CH_BASE), .ID_ADDR(ID_ADDR),
      .STAT_ADDR(STAT_ADDR), .ID_VAL(ID_VAL), .WR_MASK(WR_MASK)
   ) u_map (
      .ptr      (ptr),
      .ext_rd   (reg_rd_data),
      .status   (status_in),
      .chan_lo  (chan_lo),
      .shadow   (hi_held),
      .writable (writable),
      .lo_hit   (lo_hit),
      .rd_value (rd_value)
   );

   cra_shadow #(.NCH(NCH), .DW(DW)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (lo_hit & {NCH{rd_ok}}),
      .hi_live (chan_hi),
      .hi_held (hi_held)
   );

   assign reg_rd_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_wr_en   <= 1'b0;
         reg_wr_addr <= '0;
         reg_wr_data <= '0;
         rd_valid    <= 1'b0;
         rd_data     <= '0;
      end else begin
         reg_wr_en <= data_wr & writable;
         rd_valid  <= rd_ok;
         if (data_wr) begin
            reg_wr_addr <= ptr;
            reg_wr_data <= ev_wr_byte;
         end
         if (rd_ok) rd_data <= rd_value;
      end
   end

   a_r4_only_writable: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> WR_MASK[reg_wr_addr]);

   a_r3_strobe_from_data: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> ($past(ev_wr) && !$past(ev_wr_byte[DW-1])));

   a_r5_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(ev_rd));

   a_r10_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_open |=> (!reg_wr_en && !rd_valid && !irq_clr));

   a_r10_stop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop && !wr_ok && !rd_ok) |=> $stable(ptr));

   a_r2_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_clr) |-> !reg_wr_en);

endmodule

// File: tb/cmd_reg_access_test.sv
module cmd_reg_access_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_start = 0, ev_start_rd = 0, ev_wr = 0, ev_rd = 0, ev_stop = 0;
   logic [7:0]  ev_wr_byte = '0;
   logic [7:0]  reg_rd_data;
   logic [7:0]  status_in = 8'h5A;
   logic [63:0] chan_data = {16'hF1F0, 16'hE1E0, 16'hD1D0, 16'hC1C0};
   logic [4:0]  reg_rd_addr;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        reg_wr_en;
   logic [4:0]  reg_wr_addr;
   logic [7:0]  reg_wr_data;
   logic        irq_clr;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   assign reg_rd_data = {3'b101, reg_rd_addr};

   cmd_reg_access uut (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_start_rd(ev_start_rd),
      .ev_wr(ev_wr), .ev_wr_byte(ev_wr_byte), .ev_rd(ev_rd), .ev_stop(ev_stop),
      .reg_rd_data(reg_rd_data), .status_in(status_in), .chan_data(chan_data),
      .reg_rd_addr(reg_rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .irq_clr(irq_clr)
   );

   localparam logic [2:0] OP_SW = 3'd0, OP_SR = 3'd1, OP_P = 3'd2, OP_WB = 3'd3, OP_RB = 3'd4;
   localparam int NV = 44;
   // {op, byte, expect}: for OP_WB expect[8] = strobe, expect[4:0] = address; for OP_RB expect[7:0] = data
   localparam logic [19:0] VEC [NV] = '{
      {OP_SW, 8'h00, 9'h000},
      {OP_WB, 8'h80, 9'h000},   // R1 fixed, pointer 0x00
      {OP_WB, 8'h05, 9'h100},   // R3
      {OP_WB, 8'h06, 9'h100},   // R6
      {OP_WB, 8'hA1, 9'h000},   // R1 incrementing, pointer 0x01
      {OP_WB, 8'h11, 9'h101},   // R7
      {OP_WB, 8'h22, 9'h000},   // R4 address 0x02
      {OP_WB, 8'h33, 9'h103},   // R7
      {OP_WB, 8'h92, 9'h000},
      {OP_WB, 8'h44, 9'h000},   // R4 identity
      {OP_P,  8'h00, 9'h000},
      {OP_SR, 8'h00, 9'h000},
      {OP_RB, 8'h00, 9'h014},   // R8 identity
      {OP_RB, 8'h00, 9'h014},   // R6
      {OP_P,  8'h00, 9'h000},
      {OP_SW, 8'h00, 9'h000},
      {OP_WB, 8'hB3, 9'h000},
      {OP_P,  8'h00, 9'h000},
      {OP_SR, 8'h00, 9'h000},
      {OP_RB, 8'h00, 9'h05A},   // R8 status
      {OP_RB, 8'h00, 9'h0C0},   // R9 low
      {OP_RB, 8'h00, 9'h0C1},   // R9 high
      {OP_RB, 8'h00, 9'h0D0},
      {OP_RB, 8'h00, 9'h0D1},
      {OP_P,  8'h00, 9'h000},
      {OP_SW, 8'h00, 9'h000},
      {OP_WB, 8'h88, 9'h000},
      {OP_P,  8'h00, 9'h000},
      {OP_SR, 8'h00, 9'h000},
      {OP_RB, 8'h00, 9'h000},   // R8 unmapped
      {OP_P,  8'h00, 9'h000},
      {OP_SW, 8'h00, 9'h000},
      {OP_WB, 8'h8F, 9'h000},
      {OP_P,  8'h00, 9'h000},
      {OP_SR, 8'h00, 9'h000},
      {OP_RB, 8'h00, 9'h0AF},   // R8 external
      {OP_P,  8'h00, 9'h000},
      {OP_SW, 8'h00, 9'h000},
      {OP_WB, 8'hBF, 9'h000},
      {OP_P,  8'h00, 9'h000},
      {OP_SR, 8'h00, 9'h000},
      {OP_RB, 8'h00, 9'h000},
      {OP_RB, 8'h00, 9'h0A0},   // R7 wrap
      {OP_P,  8'h00, 9'h000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [7:0] b);
      @(negedge clk);
      case (op)
         OP_SW: begin ev_start = 1; ev_start_rd = 0; end
         OP_SR: begin ev_start = 1; ev_start_rd = 1; end
         OP_P:  ev_stop = 1;
         OP_WB: begin ev_wr = 1; ev_wr_byte = b; end
         default: ev_rd = 1;
      endcase
      @(negedge clk);
      ev_start = 0; ev_stop = 0; ev_wr = 0; ev_rd = 0;
   endtask

   task automatic rd_exp(input string tag, input logic [7:0] exp);
      drive(OP_RB, 8'h00);
      chk(tag, {24'h0, rd_valid, rd_data}, {24'h0, 1'b1, exp});
   endtask

   task automatic wr_exp(input string tag, input logic [7:0] b, input logic strobe, input logic [4:0] a);
      drive(OP_WB, b);
      if (strobe) chk(tag, {reg_wr_en, reg_wr_addr, reg_wr_data}, {1'b1, a, b});
      else        chk(tag, {31'h0, reg_wr_en}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11 reset state
      chk("R11 outputs", {reg_wr_en, rd_valid, irq_clr, reg_rd_addr}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][19:17], VEC[i][16:9]);
         if (VEC[i][19:17] == OP_WB) begin
            if (VEC[i][8]) chk($sformatf("R3 vec%0d", i), {reg_wr_en, reg_wr_addr, reg_wr_data},
                               {1'b1, VEC[i][4:0], VEC[i][16:9]});
            else           chk($sformatf("R4 vec%0d", i), {31'h0, reg_wr_en}, 32'h0);
         end else if (VEC[i][19:17] == OP_RB) begin
            chk($sformatf("R5 vec%0d", i), {rd_valid, rd_data}, {1'b1, VEC[i][7:0]});
         end
      end

      // R11 second reset: pointer 0, fixed addressing
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      chk("R11 pointer", {27'h0, reg_rd_addr}, 32'h0);
      drive(OP_SR, 8'h00);
      rd_exp("R5 stored pointer", 8'hA0);
      rd_exp("R11 fixed mode", 8'hA0);
      drive(OP_P, 8'h00);

      // R9 shadow empty after reset
      drive(OP_SW, 8'h00); wr_exp("R1 cmd", 8'h95, 0, 5'h0); drive(OP_P, 8'h00);
      drive(OP_SR, 8'h00); rd_exp("R9 shadow reset", 8'h00); drive(OP_P, 8'h00);

      // R9 coherence: live data changes on the capturing edge, then again before high read
      drive(OP_SW, 8'h00); wr_exp("R1 cmd", 8'hB8, 0, 5'h0); drive(OP_P, 8'h00);
      drive(OP_SR, 8'h00);
      @(negedge clk); ev_rd = 1; chan_data[47:32] = 16'h9988;
      @(negedge clk); ev_rd = 0;
      chk("R9 live low", {rd_valid, rd_data}, {1'b1, 8'h88});
      chan_data[47:32] = 16'h7766;
      rd_exp("R9 held high", 8'h99);
      drive(OP_P, 8'h00);

      // R2 special functions
      drive(OP_SW, 8'h00);
      wr_exp("R1 cmd", 8'h8D, 0, 5'h0);
      drive(OP_WB, 8'hE6);
      chk("R2 clear pulse", {31'h0, irq_clr}, 32'h1);
      @(negedge clk);
      chk("R2 pulse ends", {31'h0, irq_clr}, 32'h0);
      drive(OP_WB, 8'hE0);
      chk("R2 nop code", {31'h0, irq_clr}, 32'h0);
      drive(OP_WB, 8'hE3);
      chk("R2 other code", {31'h0, irq_clr}, 32'h0);
      wr_exp("R2 reserved kind", 8'hC5, 0, 5'h0);
      wr_exp("R2 pointer kept", 8'h07, 1, 5'h0D);
      drive(OP_P, 8'h00);

      // R10 events outside a matching transaction
      wr_exp("R10 wr closed", 8'h09, 0, 5'h0);
      drive(OP_RB, 8'h00);
      chk("R10 rd closed", {31'h0, rd_valid}, 32'h0);
      drive(OP_SW, 8'h00);
      drive(OP_RB, 8'h00);
      chk("R10 rd in write", {31'h0, rd_valid}, 32'h0);
      wr_exp("R10 pointer after stop", 8'h0A, 1, 5'h0D);
      drive(OP_P, 8'h00);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule